// File: doc/BRIEF.md
# Randomized Unit-Element Selector for a Multi-Bit Feedback DAC

This block sits in the feedback path of an oversampled multi-bit modulator. The feedback DAC is built from `2^BITS - 1` unit elements of the same nominal size. Each cycle the quantizer presents a thermometer-coded level with k ones. The selector turns on exactly k unit elements, so the nominal DAC output is unchanged. A pseudo-random permutation decides which elements are used, and that permutation changes on every clock. Element mismatch then stops tracking the signal and spreads out as noise that is close to white.

The permutation is a butterfly network of 2x2 swap cells, with one random bit steering each cell. The path from input to enables has no register, so the selection adds no cycle of latency inside the loop. The random bits come from a 32-bit maximal-length shift register. It advances once per clock, and a non-zero seed can be loaded into it.

Top module: `dem_rand_sel`

## Requirements
- R1: In every cycle the number of ones in `elem_en_o` equals the number of ones in `therm_i`.
- R2: When `therm_i` is all zeros, `elem_en_o` is all zeros. When `therm_i` is all ones, `elem_en_o` is all ones. This holds for every generator state.
- R3: `elem_en_o` follows `therm_i` combinationally, within the same cycle, with no clock edge needed.
- R4: For a fixed generator state the mapping is a permutation of positions. Each of the `N_ELEM` single-one inputs `1<<j` gives a single-one output, and together these outputs cover every element.
- R5: Reset (`rst_ni` low) sets the generator to `DEFAULT_SEED`. The selection sequence after reset equals the sequence that follows a load of `DEFAULT_SEED`.
- R6: If `seed_load_i` is high at a clock edge, the generator takes `seed_i` instead of stepping. Loading the same seed twice gives identical selection sequences. Different seeds give different sequences.
- R7: Loading a zero seed loads `DEFAULT_SEED` instead. The generator state is never zero.
- R8: Without a load, the generator steps once per clock edge. With the input held at level 3 (`therm_i` = 7'h07), 64 consecutive cycles show at least 8 distinct enable patterns.
- R9: With the input held at level 4 (`therm_i` = 7'h0F) for 4096 cycles, each element is enabled within ±25 % of 4096·4/7 times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| therm_i | input | N_ELEM | Thermometer-coded quantizer level |
| seed_load_i | input | 1 | Load `seed_i` into the generator at the next edge |
| seed_i | input | 32 | Seed value; zero is replaced by the default seed |
| elem_en_o | output | N_ELEM | Unit-element enables |

## Verification
A swap cell that drops or duplicates a bit shows at the ports in the same cycle. The enable count then differs from the input count, or a single-one probe lands on two elements or on none. A fault in the generator, such as a wrong reset value, an ignored seed or a stuck register, shows up on the first compared sample of a seed-replay sequence, or as a constant pattern within 64 cycles. A miswired stage that biases selection toward some elements is seen only statistically, through the usage counts over 4096 cycles.

// File: rtl/dem_pkg.sv
package dem_pkg;
  localparam int LFSR_W = 32;
  // x^32 + x^22 + x^2 + x + 1
  localparam logic [LFSR_W-1:0] LFSR_TAPS = 32'h8020_0003;
  localparam logic [LFSR_W-1:0] LFSR_DEFAULT = 32'h1ACE_B00C;
  typedef logic [LFSR_W-1:0] lfsr_t;
endpackage

// File: rtl/dem_lfsr.sv
module dem_lfsr
  import dem_pkg::*;
#(
  parameter lfsr_t DEFAULT_SEED = LFSR_DEFAULT
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  load_i,
  input  lfsr_t seed_i,
  output lfsr_t state_o
);
  lfsr_t state_q, state_d;
  logic  fb;

  assign fb = ^(state_q & LFSR_TAPS);

  always_comb begin
    if (load_i) state_d = (seed_i == '0) ? DEFAULT_SEED : seed_i;
    else        state_d = {state_q[LFSR_W-2:0], fb};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= DEFAULT_SEED;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/dem_swap_cell.sv
module dem_swap_cell (
  input  logic a_i,
  input  logic b_i,
  input  logic swap_i,
  output logic a_o,
  output logic b_o
);
  assign a_o = swap_i ? b_i : a_i;
  assign b_o = swap_i ? a_i : b_i;
endmodule

// File: rtl/dem_butterfly.sv
module dem_butterfly #(
  parameter int STAGES = 3,
  localparam int LANES  = 1 << STAGES,
  localparam int N      = LANES - 1,
  localparam int HALF   = LANES / 2,
  localparam int CTRL_W = STAGES * HALF
) (
  input  logic [N-1:0]      data_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  output logic [N-1:0]      data_o
);
  logic [N-1:0] lane [STAGES+1];
  // the pass-through cell of each stage leaves its control bit idle
  logic unused_ctrl;
  assign unused_ctrl = ^ctrl_i;

  assign lane[0] = data_i;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    localparam int DIST = 1 << (STAGES - 1 - s);
    for (genvar c = 0; c < HALF; c++) begin : g_cell
      localparam int LO = (c / DIST) * 2 * DIST + (c % DIST);
      localparam int HI = LO + DIST;
      if (HI < N) begin : g_swap
        dem_swap_cell u_cell (
          .a_i   (lane[s][LO]),
          .b_i   (lane[s][HI]),
          .swap_i(ctrl_i[s*HALF+c]),
          .a_o   (lane[s+1][LO]),
          .b_o   (lane[s+1][HI])
        );
      end else begin : g_pass
        // partner lane does not exist (element count is 2^B - 1)
        assign lane[s+1][LO] = lane[s][LO];
      end
    end
  end

  assign data_o = lane[STAGES];
endmodule

// File: rtl/dem_rand_sel.sv
module dem_rand_sel
  import dem_pkg::*;
#(
  parameter int    BITS         = 3,
  parameter lfsr_t DEFAULT_SEED = LFSR_DEFAULT,
  localparam int   N_ELEM       = (1 << BITS) - 1,
  localparam int   CTRL_W       = BITS * (1 << (BITS - 1))
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_ELEM-1:0] therm_i,
  input  logic              seed_load_i,
  input  logic [LFSR_W-1:0] seed_i,
  output logic [N_ELEM-1:0] elem_en_o
);
  lfsr_t             lfsr_state;
  logic [CTRL_W-1:0] swap_ctrl;
  logic              unused_state;

  dem_lfsr #(.DEFAULT_SEED(DEFAULT_SEED)) u_lfsr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (seed_load_i),
    .seed_i (seed_i),
    .state_o(lfsr_state)
  );

  for (genvar i = 0; i < CTRL_W; i++) begin : g_ctrl
    assign swap_ctrl[i] = lfsr_state[i % LFSR_W];
  end
  assign unused_state = ^lfsr_state;

  dem_butterfly #(.STAGES(BITS)) u_net (
    .data_i(therm_i),
    .ctrl_i(swap_ctrl),
    .data_o(elem_en_o)
  );
endmodule

// File: rtl/dem_rand_sel_chk.sv
module dem_rand_sel_chk #(
  parameter int          N_ELEM       = 7,
  parameter int          W            = 32,
  parameter logic [31:0] DEFAULT_SEED = 32'h1ACE_B00C
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [N_ELEM-1:0] therm_i,
  input logic [N_ELEM-1:0] elem_en_o,
  input logic              seed_load_i,
  input logic [W-1:0]      seed_i,
  input logic [W-1:0]      state_i
);
  p_count_match_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(elem_en_o) == $countones(therm_i));

  p_all_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (therm_i == '0) |-> (elem_en_o == '0));

  p_all_one_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (therm_i == '1) |-> (elem_en_o == '1));

  p_seed_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seed_load_i && seed_i != '0) |=> (state_i == $past(seed_i)));

  p_zero_seed_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seed_load_i && seed_i == '0) |=> (state_i == DEFAULT_SEED));

  p_never_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i != '0);

  p_steps_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seed_load_i |=> (state_i != $past(state_i)));
endmodule

bind dem_rand_sel dem_rand_sel_chk #(
  .N_ELEM(N_ELEM), .W(dem_pkg::LFSR_W), .DEFAULT_SEED(DEFAULT_SEED)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .therm_i    (therm_i),
  .elem_en_o  (elem_en_o),
  .seed_load_i(seed_load_i),
  .seed_i     (seed_i),
  .state_i    (lfsr_state)
);

// File: tb/dem_rand_sel_tb.sv
`timescale 1ns/1ps
module dem_rand_sel_tb;
  localparam int N = 7;
  localparam logic [31:0] DEF_SEED = 32'h1ACE_B00C;
  localparam int SEQ = 32;

  localparam logic [N-1:0] STIM [8] = '{7'h00, 7'h01, 7'h03, 7'h07,
                                        7'h0F, 7'h1F, 7'h3F, 7'h7F};
  localparam int EXP_CNT [8] = '{0, 1, 2, 3, 4, 5, 6, 7};

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [N-1:0]  therm_i = '0;
  logic          seed_load_i = 1'b0;
  logic [31:0]   seed_i = '0;
  logic [N-1:0]  elem_en_o;

  int checks = 0;
  int failures = 0;
  logic [N-1:0] seq_ref [SEQ];
  logic [N-1:0] seq_cur [SEQ];

  always #4 clk_i = ~clk_i;

  dem_rand_sel #(.BITS(3), .DEFAULT_SEED(DEF_SEED)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .therm_i(therm_i),
    .seed_load_i(seed_load_i), .seed_i(seed_i), .elem_en_o(elem_en_o)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  task automatic load_seed(input logic [31:0] s);
    @(negedge clk_i);
    seed_i = s; seed_load_i = 1'b1;
    @(posedge clk_i); #1;
    seed_load_i = 1'b0;
    @(negedge clk_i);
  endtask

  // samples now, then once per cycle at the falling edge
  task automatic record_seq();
    for (int i = 0; i < SEQ; i++) begin
      seq_cur[i] = elem_en_o;
      @(posedge clk_i); @(negedge clk_i);
    end
  endtask

  function automatic int seq_diffs();
    int d = 0;
    for (int i = 0; i < SEQ; i++) if (seq_cur[i] != seq_ref[i]) d++;
    return d;
  endfunction

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int cnt [N];
    int ideal, tol, distinct, d;
    logic [N-1:0] pats [64];
    logic [N-1:0] cover_v;
    bit one_hot_ok;

    // R5: reset state, sequence from reset
    therm_i = 7'h07;
    #20;
    @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    check($countones(elem_en_o) == 3, "R5 reset-state count", $countones(elem_en_o), 3);
    record_seq();
    for (int i = 0; i < SEQ; i++) seq_ref[i] = seq_cur[i];
    load_seed(DEF_SEED);
    record_seq();
    d = seq_diffs();
    check(d == 0, "R5 reset equals default seed", d, 0);

    // R7: zero seed falls back to default
    load_seed(32'h0);
    record_seq();
    d = seq_diffs();
    check(d == 0, "R7 zero seed replaced", d, 0);

    // R6: seed replay and seed sensitivity
    load_seed(32'h1234_5678);
    record_seq();
    for (int i = 0; i < SEQ; i++) seq_ref[i] = seq_cur[i];
    load_seed(32'h1234_5678);
    record_seq();
    d = seq_diffs();
    check(d == 0, "R6 same seed same sequence", d, 0);
    load_seed(32'hCAFE_F00D);
    record_seq();
    d = seq_diffs();
    check(d != 0, "R6 other seed differs", d, 1);

    // R1/R2: table walk, each level held for several cycles
    for (int t = 0; t < 8; t++) begin
      for (int k = 0; k < 4; k++) begin
        @(posedge clk_i); #1;
        therm_i = STIM[t];
        @(negedge clk_i);
        check($countones(elem_en_o) == EXP_CNT[t], "R1 count", $countones(elem_en_o), EXP_CNT[t]);
        if (t == 0) check(elem_en_o == 7'h00, "R2 all zero", elem_en_o, 7'h00);
        if (t == 7) check(elem_en_o == 7'h7F, "R2 all one", elem_en_o, 7'h7F);
      end
    end

    // R3/R4: within one cycle, probe single-one inputs without a clock edge
    for (int r = 0; r < 6; r++) begin
      @(negedge clk_i);
      cover_v = '0; one_hot_ok = 1'b1;
      for (int j = 0; j < N; j++) begin
        therm_i = 7'(1 << j);
        #0.3;
        if ($countones(elem_en_o) != 1) one_hot_ok = 1'b0;
        cover_v |= elem_en_o;
      end
      check(one_hot_ok, "R4 single-one maps to single-one", {31'd0, one_hot_ok}, 1);
      check(cover_v == 7'h7F, "R4 probes cover all elements", cover_v, 7'h7F);
      therm_i = 7'h00; #0.3;
      check(elem_en_o == 7'h00, "R3 same-cycle response zero", elem_en_o, 7'h00);
      therm_i = 7'h7F; #0.3;
      check(elem_en_o == 7'h7F, "R3 same-cycle response full", elem_en_o, 7'h7F);
    end

    // R8: pattern varies over time at level 3
    @(posedge clk_i); #1;
    therm_i = 7'h07;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk_i);
      pats[i] = elem_en_o;
    end
    distinct = 0;
    for (int i = 0; i < 64; i++) begin
      bit seen = 1'b0;
      for (int j = 0; j < i; j++) if (pats[j] == pats[i]) seen = 1'b1;
      if (!seen) distinct++;
    end
    check(distinct >= 8, "R8 distinct patterns", distinct, 8);

    // R9: usage uniformity at level 4
    for (int e = 0; e < N; e++) cnt[e] = 0;
    @(posedge clk_i); #1;
    therm_i = 7'h0F;
    for (int i = 0; i < 4096; i++) begin
      @(negedge clk_i);
      for (int e = 0; e < N; e++) if (elem_en_o[e]) cnt[e]++;
    end
    ideal = (4096 * 4) / 7;
    tol = ideal / 4;
    for (int e = 0; e < N; e++)
      check(cnt[e] >= ideal - tol && cnt[e] <= ideal + tol, "R9 element usage", cnt[e], ideal);

    // R5: reset mid-run restores default sequence
    @(negedge clk_i);
    therm_i = 7'h07;
    rst_ni = 1'b0;
    #20;
    @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    record_seq();
    for (int i = 0; i < SEQ; i++) seq_ref[i] = seq_cur[i];
    load_seed(DEF_SEED);
    record_seq();
    d = seq_diffs();
    check(d == 0, "R5 second reset equals default seed", d, 0);

    finish_run();
  end
endmodule